// File: doc/BRIEF.md
# SPI Transaction Status Tracker

This block follows each SPI transaction byte by byte and, when the transaction ends, freezes an 8-bit status byte that the next transaction can read out. It folds a running even parity over the bytes returned to the host and a separate one over every byte the host sent, including the command and address bytes. It counts payload bytes and records whether a data access was attempted while the device was busy. Two flash-mode bits are sampled at the same moment.

The serial shifter and command decoder sit outside. They present each completed byte on `byte_i` together with exactly one strobe that says what kind of byte it was. They pulse `end_i` when chip select is released. The accumulators clear on that pulse, so every transaction starts from zero.

Top module: `spi_xact_status`

## Requirements
- R1: After reset `status_o` is 0x00.
- R2: Bit 7 is 1 when a write-data or read-data strobe arrived while `busy_i` was high at any point in the transaction. Command and address strobes never set it.
- R3: Bit 6 is the XOR of all bits of every read-data byte in the transaction. The status byte itself is not a read-data strobe.
- R4: Bit 5 is the XOR of all bits of every command, address and write-data byte in the transaction.
- R5: Bits 4:2 hold the number of payload bytes (write-data plus read-data) modulo 8, for example 9 payload bytes give 3'b001.
- R6: When the transaction held three or fewer bytes in total, counting command, address and payload bytes, bits 4:2 read 3'b111.
- R7: Bit 1 is `flash_mode_i` sampled at the end pulse, forced to 0 when `test_pin_i` is low.
- R8: Bit 0 is `flash_rdy_i` sampled at the end pulse.
- R9: `status_o` changes only on the edge that samples `end_i` high. It holds its value otherwise, and the next transaction starts with clear parity, count and busy flag.
- R10: A byte strobe in the same cycle as `end_i` counts toward the status being latched and not toward the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_stb_i | input | 1 | Command byte on `byte_i` |
| addr_stb_i | input | 1 | Address byte on `byte_i` |
| wr_stb_i | input | 1 | Write-data byte on `byte_i` |
| rd_stb_i | input | 1 | Read-data byte on `byte_i` |
| byte_i | input | 8 | Byte qualified by the strobes |
| end_i | input | 1 | Transaction end pulse |
| busy_i | input | 1 | Device not ready for data access |
| test_pin_i | input | 1 | Test pin level |
| flash_mode_i | input | 1 | Flash programming mode active |
| flash_rdy_i | input | 1 | Flash can take another write |
| status_o | output | 8 | Latched status byte |

## Verification
Every field of `status_o` is due one edge after the cycle that holds `end_i` high. Strobes have no visible effect until then. The bench drives strobes and the end pulse on falling edges and compares the whole byte at the next falling edge, just after the latching rising edge. Hold checks send strobes with no end pulse and confirm the byte has not moved. Expected bytes come from per-transaction tallies the bench keeps itself.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic       not_rdy;
    logic       rd_par;
    logic       wr_par;
    logic [2:0] count;
    logic       flash_mode;
    logic       flash_rdy;
  } status_t;
endpackage

// File: rtl/parity_acc.sv
module parity_acc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic         par_nxt_o
);
  logic par_q;

  assign par_nxt_o = par_q ^ (en_i & (^data_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    par_q <= 1'b0;
    else if (clr_i) par_q <= 1'b0;
    else            par_q <= par_nxt_o;
  end

  // R9: accumulator restarts from zero after each end pulse
  assert_par_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !par_q);
endmodule

// File: rtl/byte_tally.sv
module byte_tally #(
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned SHORT_MAX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hdr_en_i,
  input  logic             pay_en_i,
  output logic [CNT_W-1:0] pay_nxt_o,
  output logic             short_nxt_o
);
  localparam int unsigned SAT = SHORT_MAX + 1;
  localparam int unsigned TW  = $clog2(SAT + 1);

  logic [CNT_W-1:0] pay_q;
  logic [TW-1:0]    tot_q, tot_nxt;
  logic             any_en;

  assign any_en    = hdr_en_i | pay_en_i;
  assign pay_nxt_o = pay_q + CNT_W'(pay_en_i);

  always_comb begin
    tot_nxt = tot_q;
    if (any_en && tot_q != TW'(SAT)) tot_nxt = tot_q + 1'b1;
  end

  assign short_nxt_o = (tot_nxt <= TW'(SHORT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_q <= '0;
      tot_q <= '0;
    end else if (clr_i) begin
      pay_q <= '0;
      tot_q <= '0;
    end else begin
      pay_q <= pay_nxt_o;
      tot_q <= tot_nxt;
    end
  end

  // R6: total byte count saturates and never passes its limit
  assert_tot_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot_q <= TW'(SAT));
  // R9: counters restart after each end pulse
  assert_cnt_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pay_q == '0 && tot_q == '0));
endmodule

// File: rtl/spi_xact_status.sv
module spi_xact_status
  import spi_stat_pkg::*;
#(
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned SHORT_MAX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_stb_i,
  input  logic              addr_stb_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              end_i,
  input  logic              busy_i,
  input  logic              test_pin_i,
  input  logic              flash_mode_i,
  input  logic              flash_rdy_i,
  output logic [7:0]        status_o
);
  logic             rd_par_nxt, wr_par_nxt, short_nxt;
  logic [CNT_W-1:0] pay_nxt;
  logic             nr_q, nr_nxt, data_stb, hdr_stb;
  status_t          stat_q, stat_d;

  assign data_stb = wr_stb_i | rd_stb_i;
  assign hdr_stb  = cmd_stb_i | addr_stb_i;
  assign nr_nxt   = nr_q | (data_stb & busy_i);

  parity_acc #(.W(BYTE_W)) u_rd_par (
    .clk_i, .rst_ni, .clr_i(end_i), .en_i(rd_stb_i),
    .data_i(byte_i), .par_nxt_o(rd_par_nxt));

  parity_acc #(.W(BYTE_W)) u_wr_par (
    .clk_i, .rst_ni, .clr_i(end_i), .en_i(hdr_stb | wr_stb_i),
    .data_i(byte_i), .par_nxt_o(wr_par_nxt));

  byte_tally #(.CNT_W(CNT_W), .SHORT_MAX(SHORT_MAX)) u_tally (
    .clk_i, .rst_ni, .clr_i(end_i), .hdr_en_i(hdr_stb),
    .pay_en_i(data_stb), .pay_nxt_o(pay_nxt), .short_nxt_o(short_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    nr_q <= 1'b0;
    else if (end_i) nr_q <= 1'b0;
    else            nr_q <= nr_nxt;
  end

  always_comb begin
    stat_d            = stat_q;
    stat_d.not_rdy    = nr_nxt;
    stat_d.rd_par     = rd_par_nxt;
    stat_d.wr_par     = wr_par_nxt;
    stat_d.count      = short_nxt ? 3'b111 : 3'(pay_nxt);
    stat_d.flash_mode = flash_mode_i & test_pin_i;
    stat_d.flash_rdy  = flash_rdy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (end_i) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  // R10: the shared byte bus carries one kind of byte per cycle
  assert_one_stb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_stb_i, addr_stb_i, wr_stb_i, rd_stb_i}));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> $stable(status_o));
  assert_test_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !test_pin_i) |=> !status_o[1]);
  assert_rdy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> status_o[0] == $past(flash_rdy_i));
  assert_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && busy_i && (wr_stb_i || rd_stb_i)) |=> status_o[7]);
endmodule

// File: tb/spi_xact_status_tb_top.sv
module spi_xact_status_tb_top;
  localparam int CLK_P = 10;
  localparam int K_CMD = 0, K_ADDR = 1, K_WR = 2, K_RD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, addr_stb = 0, wr_stb = 0, rd_stb = 0;
  logic [7:0] byte_v = '0;
  logic end_p = 0, busy = 0, test_pin = 0, fmode = 0, frdy = 0;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0;
  logic e_rd, e_wr, e_nr;
  int e_pay, e_tot;

  always #(CLK_P/2) clk = ~clk;

  spi_xact_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_stb_i(cmd_stb), .addr_stb_i(addr_stb),
    .wr_stb_i(wr_stb), .rd_stb_i(rd_stb), .byte_i(byte_v), .end_i(end_p),
    .busy_i(busy), .test_pin_i(test_pin), .flash_mode_i(fmode),
    .flash_rdy_i(frdy), .status_o(status));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clr_model();
    e_rd = 0; e_wr = 0; e_nr = 0; e_pay = 0; e_tot = 0;
  endtask

  task automatic drive(int kind, logic [7:0] b);
    cmd_stb = (kind == K_CMD); addr_stb = (kind == K_ADDR);
    wr_stb = (kind == K_WR); rd_stb = (kind == K_RD);
    byte_v = b;
    e_tot++;
    if (kind == K_RD) e_rd ^= ^b;
    else              e_wr ^= ^b;
    if (kind >= K_WR) begin
      e_pay++;
      if (busy) e_nr = 1;
    end
  endtask

  task automatic put(int kind, logic [7:0] b);
    @(negedge clk);
    drive(kind, b);
    @(negedge clk);
    {cmd_stb, addr_stb, wr_stb, rd_stb} = '0;
  endtask

  function automatic logic [7:0] expect_byte();
    logic [2:0] c;
    c = (e_tot <= 3) ? 3'b111 : 3'(e_pay);
    return {e_nr, e_rd, e_wr, c, fmode & test_pin, frdy};
  endfunction

  // end pulse; optional strobe in the same cycle (R10)
  task automatic finish(string req, int kind = -1, logic [7:0] b = 0);
    logic [7:0] exp;
    @(negedge clk);
    if (kind >= 0) drive(kind, b);
    end_p = 1;
    exp = expect_byte();
    @(negedge clk);
    end_p = 0;
    {cmd_stb, addr_stb, wr_stb, rd_stb} = '0;
    check(req, status, exp);
    clr_model();
  endtask

  task automatic t_reset();
    check("R1 reset", status, 8'h00);
  endtask

  task automatic t_write();
    put(K_CMD, 8'h02); put(K_ADDR, 8'h10); put(K_ADDR, 8'h00);
    put(K_WR, 8'hA5); put(K_WR, 8'h01); put(K_WR, 8'h07); put(K_WR, 8'hFF);
    finish("R4 R5 write parity/count");
  endtask

  task automatic t_read();
    put(K_CMD, 8'h03); put(K_ADDR, 8'h20);
    for (int i = 0; i < 5; i++) put(K_RD, 8'(8'h11 * i + 1));
    finish("R3 R5 read parity/count");
  endtask

  task automatic t_short();
    put(K_CMD, 8'h81);
    finish("R6 one byte");
    put(K_CMD, 8'h03); put(K_ADDR, 8'h00); put(K_WR, 8'h01);
    finish("R6 three bytes");
    put(K_CMD, 8'h03); put(K_ADDR, 8'h00); put(K_WR, 8'h01); put(K_WR, 8'h03);
    finish("R6 four bytes not short");
  endtask

  task automatic t_wrap();
    put(K_CMD, 8'h03); put(K_ADDR, 8'h04);
    for (int i = 0; i < 9; i++) put(K_RD, 8'(i * 3));
    finish("R5 count wraps");
  endtask

  task automatic t_busy();
    busy = 1;
    put(K_CMD, 8'h02); put(K_ADDR, 8'h01);
    busy = 0;
    put(K_WR, 8'h55); put(K_WR, 8'h66);
    finish("R2 busy on header only");
    put(K_CMD, 8'h02); put(K_ADDR, 8'h01);
    busy = 1; put(K_WR, 8'h55); busy = 0; put(K_WR, 8'h66);
    finish("R2 busy on data");
    put(K_CMD, 8'h03); put(K_ADDR, 8'h01); put(K_RD, 8'h0F); put(K_RD, 8'h01);
    finish("R9 busy flag cleared");
  endtask

  task automatic t_flash();
    fmode = 1; test_pin = 0; frdy = 1;
    put(K_CMD, 8'h01);
    finish("R7 test pin low");
    test_pin = 1; frdy = 0;
    put(K_CMD, 8'h01);
    finish("R7 R8 flash mode on");
    fmode = 0; frdy = 1;
    put(K_CMD, 8'h01);
    finish("R8 flash ready");
    test_pin = 0;
  endtask

  task automatic t_hold();
    logic [7:0] prev;
    prev = status;
    put(K_CMD, 8'h7F); put(K_ADDR, 8'h13); put(K_WR, 8'h01); put(K_WR, 8'h02);
    fmode = 1; test_pin = 1; frdy = 0;
    @(negedge clk);
    check("R9 hold without end", status, prev);
    put(K_WR, 8'h80);
    finish("R9 latched after hold");
    fmode = 0; test_pin = 0; frdy = 0;
  endtask

  task automatic t_coincide();
    put(K_CMD, 8'h03); put(K_ADDR, 8'h00); put(K_RD, 8'h01); put(K_RD, 8'h02);
    finish("R10 strobe with end", K_RD, 8'h01);
    put(K_CMD, 8'h03); put(K_ADDR, 8'h00); put(K_RD, 8'h00); put(K_RD, 8'h00);
    finish("R10 next transaction clean");
  endtask

  initial begin
    clr_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_short();
    t_wrap();
    t_busy();
    t_flash();
    t_hold();
    t_coincide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule